// File: doc/BRIEF.md
# Preset Down Counter with Zero Output

This block is an event counter that is loaded with a preset and counts down by one on each rising edge of a count input. When the present value reaches zero, an output is switched on. Counting then carries on into negative numbers, and the present value is presented as a signed quantity. A separate clear input reloads the preset and switches the output off. The clear must stay high for a programmable number of clock cycles before it is accepted. While an accepted clear is held, count edges are ignored, and counting restarts once the clear is released.

The output works in one of two ways, picked by a mode input. In hold mode it stays on until the next accepted clear. In pulse mode it stays on for a programmable number of timer ticks, where a tick is a one-cycle strobe from a shared time base. In both modes the output fires once per clear cycle. It does not fire again when the count goes negative. All inputs are synchronous to `clk`. Edge detection compares each input with its value at the previous clock.

Top module: `preset_down_counter`

## Requirements
- R1: Each accepted rising edge of `count_i` lowers `value_o` by exactly one. A rising edge means low at the previous clock and high at this clock. The new value is visible after that clock edge.
- R2: `out_o` switches on at the same clock edge at which `value_o` steps from 1 to 0.
- R3: Later count edges keep lowering `value_o` below zero, for example 0 to -1 to -2.
- R4: An accepted clear loads `value_o` with the zero-extended `preset_i` and switches `out_o` off at the same clock edge.
- R5: From the edge at which a clear is accepted until `clear_i` has been low for one clock, count edges leave `value_o` unchanged. The first count edge after that is counted again.
- R6: A clear is accepted at the clock edge at which `clear_i` has been high for `min_clear_i` consecutive cycles. A value of 0 or 1 accepts on the first cycle. A shorter high pulse has no effect on `value_o` or `out_o`.
- R7: With `hold_mode_i`=1, `out_o` stays on through count edges and ticks until an accepted clear.
- R8: With `hold_mode_i`=0, `out_o` stays on until the clock edge of the `pulse_width_i`-th cycle with `tick_i`=1 after it switched on. A width of 0 acts as a width of 1.
- R9: In either mode, `out_o` does not switch on again at count edges after the one that reached zero, until the next accepted clear.
- R10: With a preset of 0, the first count edge after a clear switches `out_o` on and takes `value_o` to -1.
- R11: `value_o` saturates at -2^(W-1) (-128 at W=8). Further count edges leave it there.
- R12: A synchronous `rst` loads `value_o` with `preset_i`, switches `out_o` off and leaves counting enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| count_i | input | 1 | Count pulse input; rising edges are counted |
| clear_i | input | 1 | Clear request; reloads the preset and blocks counting while held |
| min_clear_i | input | CW | Minimum clear width in clock cycles |
| preset_i | input | W-1 | Preset value, non-negative |
| pulse_width_i | input | PWW | Output pulse width in ticks (pulse mode) |
| hold_mode_i | input | 1 | 1 = output held until clear, 0 = timed pulse |
| tick_i | input | 1 | Time-base strobe for the pulse timer |
| value_o | output | W | Signed present value |
| out_o | output | 1 | Zero-reached output |

## Verification
The count path is driven from three starting points: a mid-range preset, a preset of zero, and a run that goes all the way down to the negative limit. Together these separate the normal step from the zero firing rule and from saturation. Clear pulses are applied one cycle shorter than the minimum and exactly at the minimum, which tells a correct width qualifier from one that accepts too early or too late. Count edges applied while a clear is held, and just after it is released, separate the inhibit window from normal counting. In pulse mode, ticks are counted up to the width and one short of it, with a width of zero included. Further count edges below zero then show that the output does not fire a second time.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic {
    OUT_PULSE = 1'b0,
    OUT_HOLD  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/pdc_edge_detect.sv
module pdc_edge_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
    assign fall_o[g] = ~sig_i[g] & prev_q[g];
  end
endmodule

// File: rtl/pdc_clear_qual.sv
module pdc_clear_qual #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic [CW-1:0] min_len_i,
  output logic          hit_o,
  output logic          active_o
);
  localparam logic [CW:0] ONE = (CW+1)'(1);

  logic [CW-1:0] held_q;
  logic [CW:0]   need;
  logic [CW:0]   seen;

  assign need  = (min_len_i == '0) ? ONE : {1'b0, min_len_i};
  assign seen  = {1'b0, held_q} + ONE;
  assign hit_o = clear_i && !active_o && (seen >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q   <= '0;
      active_o <= 1'b0;
    end else if (!clear_i) begin
      held_q   <= '0;
      active_o <= 1'b0;
    end else begin
      if (held_q != '1) held_q <= held_q + 1'b1;
      if (hit_o) active_o <= 1'b1;
    end
  end

  // R6: a clear longer than one cycle requirement is never accepted on its first high cycle
  a_r6_min_width: assert property (@(posedge clk) disable iff (rst)
    (hit_o && min_len_i > CW'(1)) |-> $past(clear_i));
  // R6: an accepted clear stays accepted while the input is held
  a_r6_stays_active: assert property (@(posedge clk) disable iff (rst)
    (hit_o && clear_i) |=> (active_o || !clear_i));
endmodule

// File: rtl/pdc_pulse_timer.sv
module pdc_pulse_timer #(
  parameter int PWW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire_i,
  input  logic           clear_i,
  input  logic           hold_i,
  input  logic [PWW-1:0] width_i,
  input  logic           tick_i,
  output logic           out_o
);
  import pdc_pkg::*;

  out_mode_e      mode;
  logic [PWW-1:0] rem_q;
  logic [PWW-1:0] load;

  assign mode = hold_i ? OUT_HOLD : OUT_PULSE;
  assign load = (width_i == '0) ? PWW'(1) : width_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      rem_q <= '0;
      out_o <= 1'b0;
    end else if (fire_i) begin
      rem_q <= load;
      out_o <= 1'b1;
    end else if (mode == OUT_PULSE && tick_i && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == PWW'(1)) out_o <= 1'b0;
    end
  end

  // R7: in hold mode the output only drops on a clear
  a_r7_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (hold_i && out_o && !clear_i) |=> out_o);
  // R8: the output only rises when a fire request arrives
  a_r8_rise_on_fire: assert property (@(posedge clk) disable iff (rst)
    (!out_o && !fire_i) |=> !out_o);
  // R8: without a tick a pulse-mode output stays on
  a_r8_no_tick_keeps: assert property (@(posedge clk) disable iff (rst)
    (out_o && !tick_i && !clear_i) |=> out_o);
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter #(
  parameter int W   = 8,
  parameter int CW  = 4,
  parameter int PWW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                count_i,
  input  logic                clear_i,
  input  logic [CW-1:0]       min_clear_i,
  input  logic [W-2:0]        preset_i,
  input  logic [PWW-1:0]      pulse_width_i,
  input  logic                hold_mode_i,
  input  logic                tick_i,
  output logic signed [W-1:0] value_o,
  output logic                out_o
);
  localparam logic signed [W-1:0] FLOOR = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] ONE   = W'(1);

  logic [1:0] rise, fall;
  logic       clr_hit, clr_active;
  logic       accept, fire, fired_q;
  logic signed [W-1:0] preset_s;

  pdc_edge_detect #(.N(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  ({clear_i, count_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  pdc_clear_qual #(.CW(CW)) u_clr (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (clear_i),
    .min_len_i (min_clear_i),
    .hit_o     (clr_hit),
    .active_o  (clr_active)
  );

  assign preset_s = $signed({1'b0, preset_i});
  assign accept   = rise[0] && !clr_active && !clr_hit;
  assign fire     = accept && !fired_q && (value_o <= ONE);

  always_ff @(posedge clk) begin
    if (rst || clr_hit) begin
      value_o <= preset_s;
      fired_q <= 1'b0;
    end else if (accept) begin
      if (value_o != FLOOR) value_o <= value_o - ONE;
      if (fire) fired_q <= 1'b1;
    end
  end

  pdc_pulse_timer #(.PWW(PWW)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire),
    .clear_i (clr_hit),
    .hold_i  (hold_mode_i),
    .width_i (pulse_width_i),
    .tick_i  (tick_i),
    .out_o   (out_o)
  );

  // clear edges are observed only for the inhibit check below
  // R1: one accepted edge moves the value down by exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (rise[0] && !clr_active && !clr_hit && value_o != FLOOR) |=> (value_o == $past(value_o) - ONE));
  // R4: an accepted clear loads the preset and drops the output
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> (value_o == $past(preset_s) && !out_o));
  // R5: while a clear is held the value does not move
  a_r5_inhibit: assert property (@(posedge clk) disable iff (rst)
    (clr_active && !fall[1]) |=> $stable(value_o));
  // R9: after firing once the output cannot rise again before a clear
  a_r9_once: assert property (@(posedge clk) disable iff (rst)
    (fired_q && !clr_hit) |=> !$rose(out_o));
  // R11: the floor is never wrapped
  a_r11_floor: assert property (@(posedge clk) disable iff (rst)
    (value_o == FLOOR && !clr_hit) |=> (value_o == FLOOR));
endmodule

// File: tb/tb_preset_down_counter.sv
module tb_preset_down_counter;
  localparam int W = 8, CW = 4, PWW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic count_i = 1'b0, clear_i = 1'b0, hold_mode_i = 1'b1, tick_i = 1'b0;
  logic [CW-1:0] min_clear_i = CW'(1);
  logic [W-2:0] preset_i = 7'd5;
  logic [PWW-1:0] pulse_width_i = 4'd3;
  logic signed [W-1:0] value_o;
  logic out_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  preset_down_counter #(.W(W), .CW(CW), .PWW(PWW)) dut (
    .clk(clk), .rst(rst), .count_i(count_i), .clear_i(clear_i),
    .min_clear_i(min_clear_i), .preset_i(preset_i), .pulse_width_i(pulse_width_i),
    .hold_mode_i(hold_mode_i), .tick_i(tick_i), .value_o(value_o), .out_o(out_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_count();
    @(negedge clk) count_i = 1'b1;
    @(negedge clk) count_i = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic do_clear(input int len);
    @(negedge clk) clear_i = 1'b1;
    repeat (len) @(negedge clk);
    clear_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R12 value", int'(value_o), 5);
    chk("R12 out", int'(out_o), 0);
  endtask

  task automatic t_count_hold();
    for (int i = 4; i >= 1; i--) begin
      pulse_count();
      chk("R1 step", int'(value_o), i);
    end
    chk("R2 out before zero", int'(out_o), 0);
    pulse_count();
    chk("R2 value zero", int'(value_o), 0);
    chk("R2 out on", int'(out_o), 1);
    pulse_count();
    chk("R3 below zero", int'(value_o), -1);
    repeat (5) tick_once();
    chk("R7 held", int'(out_o), 1);
    do_clear(1);
    chk("R4 reload", int'(value_o), 5);
    chk("R4 out off", int'(out_o), 0);
  endtask

  task automatic t_inhibit();
    preset_i = 7'd6;
    @(negedge clk) clear_i = 1'b1;
    repeat (3) pulse_count();
    chk("R5 held value", int'(value_o), 6);
    @(negedge clk) clear_i = 1'b0;
    @(negedge clk);
    pulse_count();
    chk("R5 resumes", int'(value_o), 5);
  endtask

  task automatic t_min_width();
    min_clear_i = CW'(4);
    preset_i = 7'd9;
    do_clear(3);
    chk("R6 short ignored", int'(value_o), 5);
    do_clear(4);
    chk("R6 accepted", int'(value_o), 9);
    min_clear_i = CW'(1);
  endtask

  task automatic t_pulse();
    hold_mode_i = 1'b0;
    pulse_width_i = 4'd3;
    preset_i = 7'd2;
    do_clear(1);
    pulse_count();
    pulse_count();
    chk("R2 pulse on", int'(out_o), 1);
    tick_once();
    tick_once();
    chk("R8 before width", int'(out_o), 1);
    tick_once();
    chk("R8 after width", int'(out_o), 0);
    pulse_count();
    chk("R9 no refire", int'(out_o), 0);
    pulse_count();
    chk("R9 value", int'(value_o), -2);
    chk("R9 still off", int'(out_o), 0);
    pulse_width_i = 4'd0;
    preset_i = 7'd1;
    do_clear(1);
    pulse_count();
    chk("R8 width0 on", int'(out_o), 1);
    tick_once();
    chk("R8 width0 off", int'(out_o), 0);
  endtask

  task automatic t_zero_and_floor();
    hold_mode_i = 1'b1;
    preset_i = 7'd0;
    do_clear(1);
    chk("R10 loaded", int'(value_o), 0);
    chk("R10 out off", int'(out_o), 0);
    pulse_count();
    chk("R10 fires", int'(out_o), 1);
    chk("R10 value", int'(value_o), -1);
    repeat (127) pulse_count();
    chk("R11 floor", int'(value_o), -128);
    pulse_count();
    chk("R11 saturate", int'(value_o), -128);
  endtask

  initial begin
    t_reset();
    t_count_hold();
    t_inhibit();
    t_min_width();
    t_pulse();
    t_zero_and_floor();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule